// File: doc/BRIEF.md
# Execution-Origin Peripheral Access Gate

This block sits between a CPU and one protected peripheral, an SPI master, and decides whether the CPU may reach that peripheral. It does not take a permission bit from software. Instead, it watches the CPU instruction-fetch port. A one-bit state register records whether the most recent accepted fetch came from the ROM window or from somewhere else.

While that register says "granted", the CPU-side bus request reaches the peripheral unchanged. The read data and ready signals come back unchanged, and the four SPI pins pass straight between the master and the external slave. While it says "blocked", the peripheral never sees a request. A read still completes at once, with zero data. The SPI pins are held at their idle levels in both directions.

The ROM window is set by parameters as a base address and a size. An address is inside the window when it is at or above the base and strictly below base plus size. Only cycles flagged as instruction fetches move the state. Data loads and stores have no effect on it, whatever address they use.

Top module: `exec_origin_gate`

## Requirements
- R1: After reset the gate is blocked. This holds until the first accepted instruction fetch from the ROM window.
- R2: A fetch (`fetch_valid` = 1) whose address A satisfies ROM_BASE <= A < ROM_BASE + ROM_SIZE grants access. The change takes effect from the cycle after the clock edge that accepted the fetch.
- R3: A fetch at any address outside that window, including ROM_BASE - 1 and ROM_BASE + ROM_SIZE, blocks access from the following cycle.
- R4: Cycles with `fetch_valid` = 0 leave the state unchanged. This applies to data bus accesses of any address, including ROM addresses.
- R5: While granted, `per_cs`, `per_we`, `per_addr` and `per_wdata` equal the CPU-side request. `cpu_rdata` and `cpu_ready` equal `per_rdata` and `per_ready`.
- R6: While blocked, `per_cs` is 0, so a blocked write never reaches the peripheral.
- R7: While blocked, a request with `cpu_cs` = 1 sees `cpu_ready` = 1 in the same cycle and `cpu_rdata` = 0. This holds whatever the peripheral drives.
- R8: While granted, `pad_ss_n`, `pad_sck` and `pad_mosi` follow the master's `spi_ss_n`, `spi_sck` and `spi_mosi`, and `spi_miso` follows `pad_miso`.
- R9: While blocked, `pad_ss_n` = 1, `pad_sck` = 0, `pad_mosi` = 0 and `spi_miso` = 0, regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction fetch is accepted this cycle |
| fetch_addr | input | ADDR_W | Address of that fetch |
| cpu_cs | input | 1 | CPU request to the peripheral |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |
| cpu_ready | output | 1 | Request complete |
| per_cs | output | 1 | Gated request to the peripheral |
| per_we | output | 1 | Write flag to the peripheral |
| per_addr | output | ADDR_W | Address to the peripheral |
| per_wdata | output | DATA_W | Write data to the peripheral |
| per_rdata | input | DATA_W | Peripheral read data |
| per_ready | input | 1 | Peripheral ready |
| spi_ss_n | input | 1 | Chip select from the SPI master |
| spi_sck | input | 1 | Serial clock from the SPI master |
| spi_mosi | input | 1 | Serial data out of the SPI master |
| spi_miso | output | 1 | Serial data into the SPI master |
| pad_ss_n | output | 1 | Chip select to the slave |
| pad_sck | output | 1 | Serial clock to the slave |
| pad_mosi | output | 1 | Serial data to the slave |
| pad_miso | input | 1 | Serial data from the slave |

## Verification
The only stored state is the grant bit, and every output reflects it combinationally. A wrong grant value therefore shows at the SPI pads and on the bus in the very cycle after the fetch that set it. A wrong window comparison shows up as a flipped pad level right at the boundary addresses. If a non-fetch cycle disturbs the bit, the pads change on the cycle after that access. The bench reads the grant state through the pads and the ready and data path after every swept fetch address.

// File: rtl/exec_gate_pkg.sv
package exec_gate_pkg;

  // Half-open window test: base <= a < base + size, done in 64 bits so
  // base + size never wraps for any address width up to 63.
  function automatic logic in_window(input logic [63:0] a,
                                     input logic [63:0] base,
                                     input logic [63:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

endpackage

// File: rtl/origin_window.sv
module origin_window #(
  parameter int unsigned           ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]     ROM_BASE = '0,
  parameter logic [ADDR_W:0]       ROM_SIZE = (ADDR_W+1)'(16384)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import exec_gate_pkg::*;

  localparam logic [63:0] BASE64 = 64'(ROM_BASE);
  localparam logic [63:0] SIZE64 = 64'(ROM_SIZE);

  always_comb hit = in_window(64'(addr), BASE64, SIZE64);

endmodule

// File: rtl/origin_tracker.sv
module origin_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_valid,
  input  logic rom_hit,
  output logic granted
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           granted <= 1'b0;
    else if (fetch_valid) granted <= rom_hit;
  end

  a_r1_reset_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !granted);
  a_r2_fetch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && rom_hit) |=> granted);
  a_r3_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !rom_hit) |=> !granted);
  a_r4_hold_without_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(granted));

endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              granted,
  input  logic              cpu_cs,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              per_cs,
  output logic              per_we,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata,
  input  logic              per_ready
);

  always_comb begin
    per_cs    = cpu_cs & granted;
    per_we    = cpu_we;
    per_addr  = cpu_addr;
    per_wdata = cpu_wdata;
    if (granted) begin
      cpu_rdata = per_rdata;
      cpu_ready = per_ready;
    end else begin
      cpu_rdata = '0;
      cpu_ready = cpu_cs;
    end
  end

  a_r6_blocked_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !granted |-> !per_cs);
  a_r7_blocked_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (!granted && cpu_cs) |-> (cpu_ready && cpu_rdata == '0));
  a_r5_granted_passes: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> (per_cs == cpu_cs && cpu_ready == per_ready));

endmodule

// File: rtl/spi_gate.sv
module spi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic granted,
  input  logic spi_ss_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic pad_ss_n,
  output logic pad_sck,
  output logic pad_mosi,
  input  logic pad_miso
);

  always_comb begin
    pad_ss_n = granted ? spi_ss_n : 1'b1;
    pad_sck  = spi_sck  & granted;
    pad_mosi = spi_mosi & granted;
    spi_miso = pad_miso & granted;
  end

  a_r9_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !granted |-> (pad_ss_n && !pad_sck && !pad_mosi && !spi_miso));
  a_r8_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> (pad_ss_n == spi_ss_n && pad_sck == spi_sck &&
                 pad_mosi == spi_mosi && spi_miso == pad_miso));

endmodule

// File: rtl/exec_origin_gate.sv
module exec_origin_gate #(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE = '0,
  parameter logic [ADDR_W:0]   ROM_SIZE = (ADDR_W+1)'(16384)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cpu_cs,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              per_cs,
  output logic              per_we,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata,
  input  logic              per_ready,
  input  logic              spi_ss_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              pad_ss_n,
  output logic              pad_sck,
  output logic              pad_mosi,
  input  logic              pad_miso
);

  logic rom_hit;
  logic granted;

  origin_window #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE))
    u_window (.addr(fetch_addr), .hit(rom_hit));

  origin_tracker u_tracker (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .rom_hit(rom_hit), .granted(granted));

  bus_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .granted(granted),
    .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .per_cs(per_cs), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ready(per_ready));

  spi_gate u_spi (
    .clk(clk), .rst_n(rst_n), .granted(granted),
    .spi_ss_n(spi_ss_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .pad_ss_n(pad_ss_n), .pad_sck(pad_sck), .pad_mosi(pad_mosi), .pad_miso(pad_miso));

endmodule

// File: tb/tb_exec_origin_gate.sv
module tb_exec_origin_gate;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int BASE = 'h20;
  localparam int SIZE = 'h40;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic cpu_cs = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_ready, per_cs, per_we;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata;
  logic [DW-1:0] per_rdata = 8'hA5;
  logic per_ready = 0;
  logic spi_ss_n = 0, spi_sck = 1, spi_mosi = 1, pad_miso = 1;
  logic spi_miso, pad_ss_n, pad_sck, pad_mosi;

  int checks = 0, errors = 0;
  bit done = 0;

  exec_origin_gate #(.ADDR_W(AW), .DATA_W(DW),
    .ROM_BASE(AW'(BASE)), .ROM_SIZE((AW+1)'(SIZE))) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Checks all outputs against an expected grant, with a read pending.
  task automatic check_state(input bit g, input string req);
    cpu_cs = 1; cpu_we = 0; cpu_addr = 8'h33; cpu_wdata = 8'h5C;
    spi_ss_n = 0; spi_sck = 1; spi_mosi = 1; pad_miso = 1;
    per_rdata = 8'hA5; per_ready = 0;
    #1;
    chk({req, " per_cs"}, per_cs, g);
    chk({req, " cpu_ready"}, cpu_ready, !g);
    chk({req, " cpu_rdata"}, cpu_rdata, g ? 8'hA5 : 8'h00);
    chk({req, " pins"}, {pad_ss_n, pad_sck, pad_mosi, spi_miso}, g ? 4'b0111 : 4'b1000);
  endtask

  function automatic bit exp_hit(input int a);
    return (a >= BASE) && (a < BASE + SIZE);
  endfunction

  initial begin
    // R1: blocked in reset and after release
    #(CLK_PERIOD*2 + 2);
    check_state(0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk); check_state(0, "R1 after reset");

    // R2/R3 sweep: every address, from both prior states
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk);
        fetch_valid = 1; fetch_addr = AW'(pass ? 255 - a : a);
        @(negedge clk);
        fetch_valid = 0;
        check_state(exp_hit(pass ? 255 - a : a),
                    exp_hit(pass ? 255 - a : a) ? "R2 sweep" : "R3 sweep");
      end
    end

    // R3 boundaries explicitly
    @(negedge clk); fetch_valid = 1; fetch_addr = AW'(BASE);
    @(negedge clk); fetch_addr = AW'(BASE + SIZE);
    @(negedge clk); fetch_valid = 0; check_state(0, "R3 end boundary");
    @(negedge clk); fetch_valid = 1; fetch_addr = AW'(BASE + SIZE - 1);
    @(negedge clk); fetch_valid = 0; check_state(1, "R2 last ROM word");
    @(negedge clk); fetch_valid = 1; fetch_addr = AW'(BASE - 1);
    @(negedge clk); fetch_valid = 0; check_state(0, "R3 below base");

    // R4: data accesses at ROM addresses do not grant, at others do not block
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cpu_cs = 1; cpu_we = i[0]; cpu_addr = AW'(BASE + i);
      fetch_addr = AW'(BASE + i);
      @(negedge clk); check_state(0, "R4 stays blocked");
    end
    @(negedge clk); fetch_valid = 1; fetch_addr = AW'(BASE + 4);
    @(negedge clk); fetch_valid = 0; fetch_addr = 8'hF0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); check_state(1, "R4 stays granted");
    end

    // R5/R8: granted pass-through with other patterns
    @(negedge clk);
    cpu_cs = 1; cpu_we = 1; cpu_addr = 8'h9C; cpu_wdata = 8'h3E;
    per_rdata = 8'h17; per_ready = 1;
    spi_ss_n = 1; spi_sck = 0; spi_mosi = 0; pad_miso = 0; #1;
    chk("R5 write fields", {per_cs, per_we, per_addr, per_wdata}, {2'b11, 8'h9C, 8'h3E});
    chk("R5 read return", {cpu_ready, cpu_rdata}, {1'b1, 8'h17});
    chk("R8 pins idle pattern", {pad_ss_n, pad_sck, pad_mosi, spi_miso}, 4'b1000);
    cpu_cs = 0; #1;
    chk("R5 no request", per_cs, 0);

    // R6/R7/R9: blocked write dropped, read completes with zero
    @(negedge clk); fetch_valid = 1; fetch_addr = 8'hC0;
    @(negedge clk); fetch_valid = 0;
    cpu_cs = 1; cpu_we = 1; per_ready = 0; per_rdata = 8'hFF;
    spi_ss_n = 0; spi_sck = 1; spi_mosi = 1; pad_miso = 1; #1;
    chk("R6 write dropped", per_cs, 0);
    chk("R7 ready and zero", {cpu_ready, cpu_rdata}, {1'b1, 8'h00});
    chk("R9 pins forced", {pad_ss_n, pad_sck, pad_mosi, spi_miso}, 4'b1000);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule